// File: doc/BRIEF.md
# Shared-Operator Four-Word Reduction

This block folds four operand words into one result word through a single copy of a costly two-input combinational operator. It does not build a parallel tree. A pulse on `start` captures all four words into local registers. A small sequencer then drives the operator for three consecutive cycles. On the first of these cycles both operands come straight from the captured words. On each later cycle the left operand is the registered partial result and the right operand is the next captured word. The final value is `((a op b) op c) op d`.

The operator is chosen at elaboration time: wrapping addition, unsigned maximum, or bitwise exclusive-or. All three are associative, so the chained form equals the tree form. The block gives up throughput for area: only one job runs at a time. A new job may begin in the cycle in which the previous one reports completion.

Top module: `tmr_reduce`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block returns to idle and, from that edge on, `result` reads zero and `busy` and `done` read low. The reset is synchronous and active high.
- R2: A high `start` sampled at a rising edge while `busy` is low is accepted, and `busy` reads high after that same edge.
- R3: For an accepted job with words a, b, c, d, `result` equals ((a op b) op c) op d. It becomes visible together with `done` after the third rising edge that follows the accepting edge.
- R4: `done` stays high for exactly one cycle per job. `busy` falls at the same edge at which `done` rises, so the two are never high together.
- R5: The four words are sampled only at the accepting edge. Changing `in_a`..`in_d` while the job runs has no effect on its result.
- R6: A `start` pulse that arrives while `busy` is high is ignored. The running job finishes with its own result, and no extra `done` follows.
- R7: `result` holds its value in every cycle except the one that follows the final evaluation of a job.
- R8: A `start` presented in the cycle where `done` is high is accepted, so back-to-back jobs complete every four cycles.
- R9: With the default addition operator, sums wrap modulo 2^W. For example, with W=16 and four words of 16'hFFFF, the result is 16'hFFFC.
- R10: A reset asserted while a job runs aborts the job. No `done` is produced for that job, and `result` reads zero afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a reduction; used only while not busy |
| in_a | input | W | First operand word |
| in_b | input | W | Second operand word |
| in_c | input | W | Third operand word |
| in_d | input | W | Fourth operand word |
| result | output | W | Registered reduction result |
| busy | output | 1 | High from acceptance until the result is ready |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
The addition operator is driven with small distinct words, with zeros, and with all-ones words. The all-ones case exposes the wrap-around. Distinct words in every slot would reveal a wrong multiplexer select or a skipped step. While jobs run, the inputs are overwritten with unrelated values, which shows whether capture happens only at acceptance. Stray `start` pulses during a job, back-to-back jobs, and a reset in mid-job separate a correct sequencer from one that restarts, drops a job, or leaks a stale pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_STEP1 = 3'd1,
    ST_STEP2 = 3'd2,
    ST_STEP3 = 3'd3,
    ST_DONE  = 3'd4
  } tmr_state_e;

  localparam int OP_ADD = 0;
  localparam int OP_MAX = 1;
  localparam int OP_XOR = 2;

  localparam int N_WORDS = 4;
  localparam int IDX_W   = $clog2(N_WORDS);

endpackage

// File: rtl/tmr_op.sv
module tmr_op #(
  parameter int W      = 16,
  parameter int OP_SEL = 0
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res
);
  import tmr_pkg::*;

  generate
    if (OP_SEL == OP_MAX) begin : g_max
      always_comb res = (lhs > rhs) ? lhs : rhs;
    end else if (OP_SEL == OP_XOR) begin : g_xor
      always_comb res = lhs ^ rhs;
    end else begin : g_add
      always_comb res = lhs + rhs;
    end
  endgenerate

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             capture_en,
  output logic             eval_en,
  output logic             first_sel,
  output logic [IDX_W-1:0] right_idx,
  output logic             final_step,
  output logic             busy,
  output logic             done
);

  tmr_state_e state_q, state_d;
  logic       busy_q, done_q;
  logic       can_accept;

  always_comb begin
    can_accept = (state_q == ST_IDLE) || (state_q == ST_DONE);
    capture_en = start && can_accept;
    eval_en    = (state_q == ST_STEP1) || (state_q == ST_STEP2) || (state_q == ST_STEP3);
    first_sel  = (state_q == ST_STEP1);
    final_step = (state_q == ST_STEP3);
    case (state_q)
      ST_STEP1: right_idx = IDX_W'(1);
      ST_STEP2: right_idx = IDX_W'(2);
      ST_STEP3: right_idx = IDX_W'(3);
      default:  right_idx = IDX_W'(0);
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_STEP1;
      ST_STEP1: state_d = ST_STEP2;
      ST_STEP2: state_d = ST_STEP3;
      ST_STEP3: state_d = ST_DONE;
      ST_DONE:  state_d = start ? ST_STEP1 : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= final_step;
      if (capture_en)      busy_q <= 1'b1;
      else if (final_step) busy_q <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R2
  AST_STEP1_TO_STEP2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STEP1) |=> (state_q == ST_STEP2)); // R3
  AST_STEP2_TO_STEP3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STEP2) |=> (state_q == ST_STEP3)); // R3
  AST_STEP3_TO_DONE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STEP3) |=> done); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R4
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (state_q != ST_STEP1)); // R6
  AST_ACCEPT_IN_DONE: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> (state_q == ST_STEP1)); // R8

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int W      = 16,
  parameter int OP_SEL = 0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       capture_en,
  input  logic                       eval_en,
  input  logic                       first_sel,
  input  logic [IDX_W-1:0]           right_idx,
  input  logic                       final_step,
  input  logic [N_WORDS-1:0][W-1:0]  words_in,
  output logic [W-1:0]               result
);

  logic [N_WORDS-1:0][W-1:0] opnd_q;
  logic [W-1:0]              acc_q, result_q;
  logic [W-1:0]              lhs, rhs, op_out;

  genvar gi;
  generate
    for (gi = 0; gi < N_WORDS; gi++) begin : g_capture
      always_ff @(posedge clk) begin
        if (rst)             opnd_q[gi] <= '0;
        else if (capture_en) opnd_q[gi] <= words_in[gi];
      end
    end
  endgenerate

  always_comb begin
    lhs = first_sel ? opnd_q[0] : acc_q;
    rhs = opnd_q[right_idx];
  end

  tmr_op #(.W(W), .OP_SEL(OP_SEL)) u_op (
    .lhs (lhs),
    .rhs (rhs),
    .res (op_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      result_q <= '0;
    end else begin
      if (eval_en)    acc_q    <= op_out;
      if (final_step) result_q <= op_out;
    end
  end

  assign result = result_q;

  AST_OPERANDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    eval_en |=> $stable(opnd_q)); // R5
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !final_step |=> $stable(result_q)); // R7

endmodule

// File: rtl/tmr_reduce.sv
module tmr_reduce
  import tmr_pkg::*;
#(
  parameter int W      = 16,
  parameter int OP_SEL = OP_ADD
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  input  logic [W-1:0] in_d,
  output logic [W-1:0] result,
  output logic         busy,
  output logic         done
);

  logic                      capture_en, eval_en, first_sel, final_step;
  logic [IDX_W-1:0]          right_idx;
  logic [N_WORDS-1:0][W-1:0] words;

  assign words = {in_d, in_c, in_b, in_a};

  tmr_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .capture_en (capture_en),
    .eval_en    (eval_en),
    .first_sel  (first_sel),
    .right_idx  (right_idx),
    .final_step (final_step),
    .busy       (busy),
    .done       (done)
  );

  tmr_datapath #(.W(W), .OP_SEL(OP_SEL)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .capture_en (capture_en),
    .eval_en    (eval_en),
    .first_sel  (first_sel),
    .right_idx  (right_idx),
    .final_step (final_step),
    .words_in   (words),
    .result     (result)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (result == '0 && !busy && !done)); // R1 R10

endmodule

// File: tb/test_tmr_reduce.sv
module test_tmr_reduce;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0, in_c = '0, in_d = '0;
  logic [W-1:0] result;
  logic         busy, done;

  int checks = 0;
  int failures = 0;
  int done_seen = 0;
  int jobs_expected = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] last_exp = '0;

  always #5 clk = ~clk;

  tmr_reduce #(.W(W)) i_tmr_reduce (
    .clk(clk), .rst(rst), .start(start),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
    .result(result), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Called at a negedge; returns at the negedge of the done cycle.
  task automatic run_job(input logic [W-1:0] a, b, c, d, input bit poke_start);
    logic [W-1:0] e;
    e = a + b + c + d;
    in_a = a; in_b = b; in_c = c; in_d = d; start = 1'b1;
    exp_q.push_back(e);
    jobs_expected++;
    last_exp = e;
    @(negedge clk);
    start = 1'b0;
    in_a = ~a; in_b = a ^ 16'h5A5A; in_c = 16'h1234; in_d = d + 16'd77;   // R5 disturbance
    check(busy === 1'b1, "R2 busy after accept", {15'd0, busy}, 16'd1);
    for (int k = 0; k < 2; k++) begin
      if (poke_start) begin
        start = (k == 0);                                                   // R6 stray start
        in_a = 16'h0F0F;
      end
      @(negedge clk);
      check(busy === 1'b1 && done === 1'b0, "R3 running, no early done", {14'd0, busy, done}, 16'd2);
    end
    start = 1'b0;
    @(negedge clk);
    check(done === 1'b1, "R3 done after third edge", {15'd0, done}, 16'd1);
    check(busy === 1'b0, "R4 busy falls with done", {15'd0, busy}, 16'd0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (done === 1'b1) begin
      done_seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R6/R10 unexpected done", result, '0);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(result === e, "R3 result value", result, e);
      end
    end
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(result === '0 && busy === 1'b0 && done === 1'b0, "R1 reset state", result, '0);
    rst = 1'b0;
    @(negedge clk);

    run_job(16'd1, 16'd2, 16'd3, 16'd4, 1'b0);
    @(negedge clk);
    check(done === 1'b0, "R4 done single cycle", {15'd0, done}, 16'd0);
    repeat (3) @(negedge clk);
    check(result === last_exp, "R7 result holds while idle", result, last_exp);

    run_job(16'd0, 16'd0, 16'd0, 16'd0, 1'b0);
    @(negedge clk);
    run_job(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0);             // R9 wrap
    check(result === 16'hFFFC, "R9 wrap-around sum", result, 16'hFFFC);
    @(negedge clk);
    run_job(16'h1000, 16'h0200, 16'h0030, 16'h0004, 1'b1);             // R6
    repeat (4) @(negedge clk);
    check(busy === 1'b0, "R6 stray start ignored", {15'd0, busy}, 16'd0);

    // R8 back-to-back
    run_job(16'd10, 16'd20, 16'd30, 16'd40, 1'b0);
    run_job(16'hA000, 16'h0B00, 16'h00C0, 16'h000D, 1'b0);
    run_job(16'h8000, 16'h8000, 16'd5, 16'd6, 1'b0);
    @(negedge clk);
    check(done_seen == jobs_expected, "R8 one done per job", done_seen[W-1:0], jobs_expected[W-1:0]);

    // R10 reset during a job
    in_a = 16'd9; in_b = 16'd9; in_c = 16'd9; in_d = 16'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(result === '0 && busy === 1'b0 && done === 1'b0, "R10 reset aborts job", result, '0);
    repeat (6) @(negedge clk);
    check(done_seen == jobs_expected && exp_q.size() == 0, "R10 no done after abort",
          done_seen[W-1:0], jobs_expected[W-1:0]);

    run_job(16'd100, 16'd200, 16'd300, 16'd400, 1'b0);
    @(negedge clk);
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 16'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule